// File: doc/BRIEF.md
# Reference Phase Comparator with Width-Multiplying Correction Pulses

This block measures the time skew between two events in the system clock domain: the moment a decade counter reports its terminal count, and the rising edge of a time-base reference. Each event arms its own capture flag. While only one flag is armed, the skew is accumulating. Once both are armed, both flags drop together a short fixed delay later. The interval in which exactly one flag is armed becomes a correction request. A counter-first skew asks for a downward correction, and a reference-first skew asks for an upward one.

Each correction request is lengthened in proportion to its width by a separate multiplying stretcher, one for each direction. The stretched pulses drive an external charge pump. An expand select switches to a much larger multiplier, for fine resolution. When lock is not enabled, the block holds every flag and stretcher cleared, ignores both events, and raises a request for the loop voltage to be biased to mid-range.

Top module: `phase_skew_detector`

## Requirements
- R1: While reset is asserted and after it is released, `pump_up` and `pump_dn` are low and `bias_mid` is high until lock is enabled. One clock edge after `lock_en` is sampled high, `bias_mid` is low.
- R2: With lock enabled and expand off, a `tc_strobe` rising edge that precedes a `tb_edge` rising edge by D cycles (D ≥ 1) yields a single `pump_dn` pulse exactly D×8 cycles long, and `pump_up` stays low.
- R3: With lock enabled and expand off, a `tb_edge` rising edge that precedes a `tc_strobe` rising edge by D cycles yields a single `pump_up` pulse exactly D×8 cycles long, and `pump_dn` stays low.
- R4: Rising edges of both events in the same cycle produce no pulse on either output.
- R5: Two cycles after both capture flags are armed, both clear together. A following event pair is then measured afresh, and its stretched width adds to any stretch still running in the same direction.
- R6: With `expand_sel` high, the multiplier is 80 instead of 8.
- R7: While `lock_en` is low, both outputs are low and `bias_mid` is high from the next clock edge on. Events arriving then produce no pulse, and dropping lock in the middle of a pulse ends it at the next edge.
- R8: The up and down stretchers are independent. When they overlap, each output carries exactly its own stretched width.
- R9: Only rising edges arm a flag. An event input held high after its pair has been measured produces no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tc_strobe | input | 1 | Counter terminal-count event, synchronous to clk |
| tb_edge | input | 1 | Time-base reference event, synchronous to clk |
| lock_en | input | 1 | High to run the comparison; low forces the neutral state |
| expand_sel | input | 1 | High selects the large stretch multiplier |
| pump_up | output | 1 | Stretched request to raise the loop voltage (reference led) |
| pump_dn | output | 1 | Stretched request to lower the loop voltage (counter led) |
| bias_mid | output | 1 | Request to hold the loop voltage at mid-range |

## Verification
The event pairs are driven with the counter leading, with the reference leading, and with both arriving in the same cycle. The measured pulse widths show whether the skew is routed to the correct direction and scaled by the correct multiplier in each mode. Back-to-back pairs in one direction, and pairs in opposite directions that overlap, show whether the flags really clear after a pair and whether the two stretchers stay independent. Events during lock-off, a lock drop in mid-pulse, and inputs left high after their edge separate true edge capture and neutral forcing from level-sensitive or sticky behaviour.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Channel indices shared by the capture and stretch stages.
  localparam int CH_TC  = 0;   // counter terminal count
  localparam int CH_TB  = 1;   // time-base reference
  localparam int NUM_CH = 2;

  // Event pair as seen at the block edge.
  typedef struct packed {
    logic tb;
    logic tc;
  } evt_pair_t;

endpackage

// File: rtl/psd_reset_sync.sv
module psd_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/psd_capture.sv
module psd_capture
  import psd_pkg::*;
#(
  parameter int CLR_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_en,
  input  evt_pair_t         evt_in,
  output logic [NUM_CH-1:0] lead_o
);

  localparam int CW = $clog2(CLR_DLY + 1);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLR_DLY - 1);

  logic [NUM_CH-1:0] evt_vec;
  logic [NUM_CH-1:0] prev_q;
  logic [NUM_CH-1:0] rise;
  logic [NUM_CH-1:0] flag_q;
  logic [NUM_CH-1:0] flag_d;
  logic [CW-1:0]     clr_cnt_q;
  logic [CW-1:0]     clr_cnt_d;
  logic              both_set;
  logic              clr_fire;
  logic              cnt_en;

  assign evt_vec[CH_TC] = evt_in.tc;
  assign evt_vec[CH_TB] = evt_in.tb;

  assign both_set = &flag_q;
  assign clr_fire = both_set && (clr_cnt_q == CLR_LAST);

  // Clear-delay counter: runs only while both flags are armed.
  always_comb begin
    if (lock_en && both_set && !clr_fire) begin
      clr_cnt_d = clr_cnt_q + CW'(1);
    end else begin
      clr_cnt_d = '0;
    end
  end

  assign cnt_en = (clr_cnt_q != '0) || both_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_cnt_q <= '0;
    end else if (cnt_en) begin
      clr_cnt_q <= clr_cnt_d;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_chan
      // Edge detector: the previous level is tracked at all times, so an
      // input that is already high when lock is entered does not arm.
      assign rise[gi] = evt_vec[gi] & ~prev_q[gi];

      always_comb begin
        if (!lock_en) begin
          flag_d[gi] = 1'b0;
        end else if (clr_fire) begin
          flag_d[gi] = 1'b0;
        end else begin
          flag_d[gi] = flag_q[gi] | rise[gi];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q[gi] <= 1'b0;
        end else begin
          prev_q[gi] <= evt_vec[gi];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag_q[gi] <= 1'b0;
        end else if (flag_q[gi] || rise[gi] || !lock_en) begin
          flag_q[gi] <= flag_d[gi];
        end
      end

      // A flag may only arm after a rising edge on its own event.
      AST_FLAG_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[gi]) |-> $past(rise[gi]));  // R9
    end
  endgenerate

  // Lead intervals: exactly one flag armed.
  assign lead_o[CH_TC] = flag_q[CH_TC] & ~flag_q[CH_TB];
  assign lead_o[CH_TB] = flag_q[CH_TB] & ~flag_q[CH_TC];

  AST_CLEAR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[CH_TC]) |-> !flag_q[CH_TB]);  // R5

  AST_CLEAR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (flag_q == '0));  // R5

  AST_FLAGS_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en |=> (flag_q == '0));  // R7

endmodule

// File: rtl/psd_stretch.sv
module psd_stretch #(
  parameter int K_NORM  = 8,
  parameter int K_EXP   = 80,
  parameter int MAX_ERR = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_en,
  input  logic expand_sel,
  input  logic err_i,
  output logic pulse_o
);

  localparam int ACC_MAX = MAX_ERR * K_EXP;
  localparam int AW      = $clog2(ACC_MAX + 1);
  localparam logic [AW:0]   SUM_CAP = (AW+1)'(ACC_MAX);
  localparam logic [AW-1:0] ACC_CAP = AW'(ACC_MAX);

  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_d;
  logic [AW-1:0] gain;
  logic [AW:0]   sum;
  logic          acc_busy;
  logic          acc_en;

  assign acc_busy = (acc_q != '0);

  // Each cycle of error adds the gain, each active cycle drains one:
  // an error of W cycles gives an output of W*gain cycles.
  always_comb begin
    gain = expand_sel ? AW'(K_EXP) : AW'(K_NORM);
    sum  = {1'b0, acc_q}
         + (err_i ? {1'b0, gain} : '0)
         - (acc_busy ? (AW+1)'(1) : '0);
    if (!lock_en) begin
      acc_d = '0;
    end else if (sum > SUM_CAP) begin
      acc_d = ACC_CAP;
    end else begin
      acc_d = sum[AW-1:0];
    end
  end

  assign acc_en = acc_busy || err_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign pulse_o = acc_busy;

  AST_STRETCH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(err_i));  // R8

  AST_STRETCH_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en |=> !pulse_o);  // R7

endmodule

// File: rtl/phase_skew_detector.sv
module phase_skew_detector
  import psd_pkg::*;
#(
  parameter int CLR_DLY = 2,
  parameter int K_NORM  = 8,
  parameter int K_EXP   = 80,
  parameter int MAX_ERR = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tc_strobe,
  input  logic tb_edge,
  input  logic lock_en,
  input  logic expand_sel,
  output logic pump_up,
  output logic pump_dn,
  output logic bias_mid
);

  logic              rst_int_n;
  evt_pair_t         evt;
  logic [NUM_CH-1:0] lead;
  logic [NUM_CH-1:0] stretched;
  logic              bias_q;
  logic              bias_d;

  psd_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign evt.tc = tc_strobe;
  assign evt.tb = tb_edge;

  psd_capture #(.CLR_DLY(CLR_DLY)) u_cap (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .lock_en (lock_en),
    .evt_in  (evt),
    .lead_o  (lead)
  );

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_str
      psd_stretch #(
        .K_NORM  (K_NORM),
        .K_EXP   (K_EXP),
        .MAX_ERR (MAX_ERR)
      ) u_str (
        .clk        (clk),
        .rst_n      (rst_int_n),
        .lock_en    (lock_en),
        .expand_sel (expand_sel),
        .err_i      (lead[gc]),
        .pulse_o    (stretched[gc])
      );
    end
  endgenerate

  // Counter first means the loop runs fast: ask for less voltage.
  assign pump_dn = stretched[CH_TC];
  assign pump_up = stretched[CH_TB];

  always_comb begin
    bias_d = ~lock_en;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bias_q <= 1'b1;
    end else begin
      bias_q <= bias_d;
    end
  end

  assign bias_mid = bias_q;

  AST_NEUTRAL_STATE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !lock_en |=> (bias_mid && !pump_up && !pump_dn));  // R7

  AST_BIAS_RELEASE: assert property (@(posedge clk) disable iff (!rst_int_n)
    lock_en |=> !bias_mid);  // R1

endmodule

// File: tb/phase_skew_detector_bench.sv
module phase_skew_detector_bench;

  localparam int CLK_PERIOD = 10;
  localparam int KN = 8;
  localparam int KE = 80;

  logic clk;
  logic rst_n;
  logic tc_strobe;
  logic tb_edge;
  logic lock_en;
  logic expand_sel;
  logic pump_up;
  logic pump_dn;
  logic bias_mid;

  int n_checks;
  int n_errors;
  int up_hi, dn_hi, up_rises, dn_rises;
  logic up_prev, dn_prev;
  logic done;

  phase_skew_detector u_phase_skew_detector (
    .clk        (clk),
    .rst_n      (rst_n),
    .tc_strobe  (tc_strobe),
    .tb_edge    (tb_edge),
    .lock_en    (lock_en),
    .expand_sel (expand_sel),
    .pump_up    (pump_up),
    .pump_dn    (pump_dn),
    .bias_mid   (bias_mid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle: sample outputs at the falling edge, then return for driving.
  task automatic tick();
    @(negedge clk);
    if (pump_up) up_hi++;
    if (pump_dn) dn_hi++;
    if (pump_up && !up_prev) up_rises++;
    if (pump_dn && !dn_prev) dn_rises++;
    up_prev = pump_up;
    dn_prev = pump_dn;
  endtask

  task automatic meas_reset();
    up_hi = 0; dn_hi = 0; up_rises = 0; dn_rises = 0;
    up_prev = pump_up;
    dn_prev = pump_dn;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // Single-cycle event pulses; d = 0 means coincident.
  task automatic fire_pair(input bit tc_first, input int d);
    tick();
    if (d == 0) begin
      tc_strobe = 1'b1; tb_edge = 1'b1;
      tick();
      tc_strobe = 1'b0; tb_edge = 1'b0;
    end else begin
      if (tc_first) tc_strobe = 1'b1; else tb_edge = 1'b1;
      tick();
      tc_strobe = 1'b0; tb_edge = 1'b0;
      for (int i = 0; i < d - 1; i++) tick();
      if (tc_first) tb_edge = 1'b1; else tc_strobe = 1'b1;
      tick();
      tc_strobe = 1'b0; tb_edge = 1'b0;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tc_strobe = 1'b0; tb_edge = 1'b0;
    lock_en = 1'b0; expand_sel = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "pump_up in reset", int'(pump_up), 0);
    check("R1", "pump_dn in reset", int'(pump_dn), 0);
    check("R1", "bias_mid in reset", int'(bias_mid), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "bias_mid unlocked", int'(bias_mid), 1);
    lock_en = 1'b1;
    @(negedge clk);
    check("R1", "bias_mid locked", int'(bias_mid), 0);
    meas_reset();
  endtask

  task automatic t_lead(input string req, input bit tc_first, input int d, input bit exp_mode);
    int k;
    k = exp_mode ? KE : KN;
    expand_sel = exp_mode;
    meas_reset();
    fire_pair(tc_first, d);
    idle(d * k + 12);
    if (tc_first) begin
      check(req, "pump_dn width", dn_hi, d * k);
      check(req, "pump_dn pulses", dn_rises, 1);
      check(req, "pump_up width", up_hi, 0);
    end else begin
      check(req, "pump_up width", up_hi, d * k);
      check(req, "pump_up pulses", up_rises, 1);
      check(req, "pump_dn width", dn_hi, 0);
    end
    expand_sel = 1'b0;
  endtask

  task automatic t_coincident();
    meas_reset();
    fire_pair(1'b1, 0);
    idle(20);
    check("R4", "pump_up width", up_hi, 0);
    check("R4", "pump_dn width", dn_hi, 0);
  endtask

  task automatic t_back_to_back();
    meas_reset();
    fire_pair(1'b1, 2);
    idle(4);
    fire_pair(1'b1, 4);
    idle(70);
    check("R5", "pump_dn merged width", dn_hi, 6 * KN);
    check("R5", "pump_dn pulses", dn_rises, 1);
    check("R5", "pump_up width", up_hi, 0);
  endtask

  task automatic t_overlap();
    meas_reset();
    fire_pair(1'b1, 4);
    idle(5);
    fire_pair(1'b0, 2);
    idle(50);
    check("R8", "pump_dn width", dn_hi, 4 * KN);
    check("R8", "pump_up width", up_hi, 2 * KN);
    check("R8", "pump_up pulses", up_rises, 1);
  endtask

  task automatic t_lock_off();
    lock_en = 1'b0;
    idle(2);
    check("R7", "bias_mid unlocked", int'(bias_mid), 1);
    meas_reset();
    fire_pair(1'b1, 3);
    fire_pair(1'b0, 3);
    idle(40);
    check("R7", "pump_dn while unlocked", dn_hi, 0);
    check("R7", "pump_up while unlocked", up_hi, 0);
    lock_en = 1'b1;
    idle(3);
    meas_reset();
    fire_pair(1'b1, 5);
    idle(6);
    check("R7", "pump_dn active before drop", int'(pump_dn), 1);
    lock_en = 1'b0;
    tick();
    check("R7", "pump_dn after drop", int'(pump_dn), 0);
    check("R7", "bias_mid after drop", int'(bias_mid), 1);
    idle(50);
    check("R7", "pump_dn stays low", int'(pump_dn), 0);
    lock_en = 1'b1;
    idle(3);
    meas_reset();
    fire_pair(1'b1, 0);
    idle(20);
    check("R7", "no stale flag up", up_hi, 0);
    check("R7", "no stale flag dn", dn_hi, 0);
  endtask

  task automatic t_held_high();
    meas_reset();
    tick();
    tc_strobe = 1'b1;
    idle(3);
    tb_edge = 1'b1;
    idle(60);
    check("R9", "pump_dn width held", dn_hi, 3 * KN);
    check("R9", "pump_dn pulses held", dn_rises, 1);
    check("R9", "pump_up width held", up_hi, 0);
    tc_strobe = 1'b0; tb_edge = 1'b0;
    idle(5);
  endtask

  initial begin
    n_checks = 0; n_errors = 0; done = 1'b0;
    t_reset();
    t_lead("R2", 1'b1, 3, 1'b0);
    t_lead("R3", 1'b0, 5, 1'b0);
    t_coincident();
    t_back_to_back();
    t_lead("R6", 1'b0, 3, 1'b1);
    t_lead("R6", 1'b1, 1, 1'b1);
    t_overlap();
    t_lock_off();
    t_held_high();
    t_lead("R2", 1'b1, 1, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule